// File: doc/BRIEF.md
# Byte-Handshaked Two-Wire Bus Master

This block is a master for a two-wire open-drain serial bus (SCL clock, SDA data). Software runs it one bus event at a time through three registers: a control register, a data register and a status register. The block places START, repeated START and STOP conditions on the bus. It shifts out an address byte whose least significant bit selects the direction, and then moves data bytes out of or into the data register.

After every bus event except STOP, the block raises a flag and posts a numeric status code. It then holds SCL low until software clears the flag. A write to the data register while the flag is low is refused and latches a collision bit. After a repeated START, software may send the address again with the opposite direction bit, which turns a write transfer into a read transfer or the reverse.

The bus lines are driven as open-drain enables: a 1 pulls the wire low and a 0 releases it. SCL is derived from the system clock. One bit lasts four quarter-periods of DIV clocks each.

Top module: `i2c_byte_master`

## Requirements
- R1: Out of reset the status reads 0xF8, the flag (ctrl_rd bit 7) is low, and both scl_oe and sda_oe are 0.
- R2: A control write with start (bit 5) and enable (bit 0) set, made while idle, produces a START condition. The flag then rises, the status reads 0x08, and the start bit in ctrl_rd bit 5 reads 0.
- R3: While the flag is high after a START or a byte, SCL is held low and no SCL pulse occurs. A control write with bit 7 set clears the flag and lets the next action proceed.
- R4: A data write made while the flag is low leaves the data register unchanged and sets the collision bit (ctrl_rd bit 3). A data write made while the flag is high stores the byte and clears the collision bit.
- R5: The byte sent after a START carries the 7-bit address in data bits 7:1 and the direction in bit 0 (1 = read). After it the status reads 0x18 or 0x20 for write (acknowledged or not) and 0x40 or 0x48 for read.
- R6: In write direction each data byte is sent MSB first, and the status then reads 0x28 if acknowledged or 0x30 if not.
- R7: In read direction a byte is received MSB first into the data register and is valid while the flag is high. The master drives ACK after the byte if the acknowledge-enable bit (ctrl_rd bit 6) is 1, giving status 0x50, and NACK if it is 0, giving status 0x58.
- R8: A start request together with a flag clear, made after a byte, produces a repeated START with status 0x10. The next byte is again an address, so the direction can change.
- R9: A stop request (bit 4) together with a flag clear produces a STOP condition. The block then returns to status 0xF8 with the flag low and both lines released, and the stop bit clears itself.
- R10: If SDA is sampled low while the master is sending a 1 in an address or write-data bit, arbitration is lost. Both lines are released, the flag rises and the status reads 0x38.
- R11: A byte transfer gives exactly nine SCL pulses, 4*DIV clocks apart. Within transfers, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_ctrl | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write: bit 7 clear flag, 6 ack enable, 5 start, 4 stop, 0 enable |
| wr_data | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write value |
| sda_in | input | 1 | Sampled SDA wire level |
| ctrl_rd | output | 8 | Control readback: 7 flag, 6 ack enable, 5 start, 4 stop, 3 collision, 0 enable |
| status | output | 8 | Status code of the last event |
| rdata | output | 8 | Data register contents |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check every cycle that SCL stays low while a handshake is pending (unless arbitration was lost), and that the idle status implies a released clock line and a low flag. They also check that data writes set or clear the collision bit as required, that every flag rise carries a legal code, and that SDA only moves under a low SCL inside byte transfers. Only the bench scenarios, run against a behavioural slave and a rival bus driver, can show the exact code sequence for each path. The same holds for the MSB-first byte contents in both directions, the ACK/NACK choice, the direction change after a repeated START, the pulse count and period, and the release of both lines after STOP or lost arbitration.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] ctrl_wdata,
  input  logic       wr_data,
  input  logic [7:0] data_wdata,
  input  logic       sda_in,
  output logic [7:0] ctrl_rd,
  output logic [7:0] status,
  output logic [7:0] rdata,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_WAIT = 3'd1, S_START = 3'd2, S_STOP = 3'd3, S_XFER = 3'd4;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh, dreg, stat;
  logic flag, ack_en, sta, sto, ena, wcol, rep, addr_ph, rd, sda_q, ack_in;

  logic active, tick, tx, go;
  assign active = (st == S_START) || (st == S_STOP) || (st == S_XFER);
  assign tick   = active && (cnt == CW'(DIV - 1));
  assign tx     = addr_ph || !rd;
  assign go     = !flag && ena && ((st == S_WAIT) || ((st == S_IDLE) && sta));

  assign scl_oe = (st == S_WAIT) || (((st == S_START) || (st == S_STOP)) && (ph == 2'd0)) ||
                  ((st == S_XFER) && !ph[1]);
  assign sda_oe = (st == S_START) ? ph[1] :
                  (st == S_STOP)  ? !ph[1] :
                  (((st == S_XFER) || (st == S_WAIT)) && sda_q);

  assign ctrl_rd = {flag, ack_en, sta, sto, wcol, 2'b00, ena};
  assign status  = stat;
  assign rdata   = dreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= '0; bitn <= '0;
      sh <= '0; dreg <= '0; stat <= 8'hF8;
      flag <= 1'b0; ack_en <= 1'b0; sta <= 1'b0; sto <= 1'b0; ena <= 1'b0;
      wcol <= 1'b0; rep <= 1'b0; addr_ph <= 1'b0; rd <= 1'b0; sda_q <= 1'b0; ack_in <= 1'b0;
    end else begin
      cnt <= (tick || !active) ? '0 : cnt + 1'b1;

      if (wr_ctrl) begin
        ack_en <= ctrl_wdata[6];
        sta    <= ctrl_wdata[5];
        sto    <= ctrl_wdata[4];
        ena    <= ctrl_wdata[0];
        if (ctrl_wdata[7]) flag <= 1'b0;
      end

      if (wr_data) begin
        if (flag) begin
          dreg <= data_wdata;
          wcol <= 1'b0;
        end else begin
          wcol <= 1'b1;
        end
      end

      case (st)
        S_IDLE: if (go) begin
          st  <= S_START;
          ph  <= 2'd1;
          rep <= 1'b0;
        end
        S_WAIT: if (go) begin
          ph   <= 2'd0;
          bitn <= '0;
          if (sto) st <= S_STOP;
          else if (sta) begin
            st  <= S_START;
            rep <= 1'b1;
          end else begin
            st <= S_XFER;
            sh <= dreg;
            if (addr_ph) rd <= dreg[0];
          end
        end
        S_START: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd3) begin
            st      <= S_WAIT;
            flag    <= 1'b1;
            stat    <= rep ? 8'h10 : 8'h08;
            addr_ph <= 1'b1;
            sta     <= 1'b0;
            sda_q   <= 1'b1;
          end
        end
        S_STOP: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd2) begin
            st    <= S_IDLE;
            stat  <= 8'hF8;
            sto   <= 1'b0;
            sda_q <= 1'b0;
          end
        end
        S_XFER: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_q <= bitn[3] ? (!tx && ack_en) : (tx && !sh[7]);
            2'd2: begin
              if (bitn[3]) ack_in <= !sda_in;
              else begin
                sh <= {sh[6:0], sda_in};
                if (tx && !sda_q && !sda_in) begin
                  st      <= S_IDLE;
                  flag    <= 1'b1;
                  stat    <= 8'h38;
                  sda_q   <= 1'b0;
                  addr_ph <= 1'b0;
                end
              end
            end
            2'd3: begin
              if (bitn[3]) begin
                st      <= S_WAIT;
                flag    <= 1'b1;
                addr_ph <= 1'b0;
                if (!tx) dreg <= sh;
                if (addr_ph) stat <= rd ? (ack_in ? 8'h40 : 8'h48) : (ack_in ? 8'h18 : 8'h20);
                else if (rd) stat <= sda_q ? 8'h50 : 8'h58;
                else stat <= ack_in ? 8'h28 : 8'h30;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_data,
  input logic [7:0] data_wdata,
  input logic [7:0] ctrl_rd,
  input logic [7:0] status,
  input logic [7:0] rdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] st
);
  logic in_b;
  assign in_b = (st == 3'd1) || (st == 3'd4);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'hF8) |-> (!ctrl_rd[7] && !scl_oe));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7] && status != 8'h38) |-> scl_oe);

  // R4
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ctrl_rd[7]) |=> ctrl_rd[3]);

  // R4
  taken_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ctrl_rd[7]) |=> (!ctrl_rd[3] && rdata == $past(data_wdata)));

  // R5
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[7]) |-> (status inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30,
                                          8'h38, 8'h40, 8'h48, 8'h50, 8'h58}));

  // R11
  sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_b && $past(in_b) && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .data_wdata(data_wdata),
  .ctrl_rd(ctrl_rd), .status(status), .rdata(rdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .st(st)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam int DIV = 4;
  localparam logic [6:0] SADDR = 7'h52;
  localparam logic [7:0] CLR = 8'h80, ACK = 8'h40, STA = 8'h20, STO = 8'h10, EN = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_ctrl = 1'b0, wr_data = 1'b0;
  logic [7:0] ctrl_wdata = '0, data_wdata = '0;
  logic [7:0] ctrl_rd, status, rdata;
  logic scl_oe, sda_oe;
  logic s_pull = 1'b0, rival = 1'b0;
  wire  sda_w = ~(sda_oe | s_pull | rival);
  wire  scl_w = ~scl_oe;

  always #2 clk = ~clk;

  i2c_byte_master #(.DIV(DIV)) u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .ctrl_wdata(ctrl_wdata),
    .wr_data(wr_data), .data_wdata(data_wdata), .sda_in(sda_w),
    .ctrl_rd(ctrl_rd), .status(status), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {logic [7:0] code; bit chkd; logic [7:0] d; string tag;} item_t;
  item_t sb[$];

  task automatic expect_ev(input logic [7:0] code, input bit chkd, input logic [7:0] d, input string tag);
    sb.push_back('{code, chkd, d, tag});
  endtask

  // scoreboard monitor
  bit flag_d = 0;
  always @(negedge clk) begin
    if (rst_n && ctrl_rd[7] && !flag_d) begin
      if (sb.size() == 0) chk(0, "R5 unexpected event", {24'd0, status}, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(status == it.code, it.tag, {24'd0, status}, {24'd0, it.code});
        if (it.chkd) chk(rdata == it.d, it.tag, {24'd0, rdata}, {24'd0, it.d});
      end
    end
    flag_d = ctrl_rd[7];
  end

  // SCL pulse counter
  int cyc = 0, rises = 0, per = 0, last_rise = 0;
  always @(posedge clk) cyc++;
  always @(posedge scl_w) begin
    rises++;
    per = cyc - last_rise;
    last_rise = cyc;
  end

  // behavioural slave
  int bitc = 0, tptr = 0;
  bit s_act = 0, s_addr = 0, s_rd = 0, s_match = 0, mack = 0;
  logic [7:0] sbyte = '0, txb = '0;
  logic [7:0] wlog[$];
  logic [7:0] rdv [2] = '{8'hC3, 8'h5A};

  function automatic logic [7:0] next_tx();
    logic [7:0] v;
    v = (tptr < 2) ? rdv[tptr] : 8'hFF;
    tptr++;
    return v;
  endfunction

  always @(negedge sda_w) if (scl_w) begin
    s_act = 1; s_addr = 1; bitc = 0; s_pull = 0; s_rd = 0;
  end
  always @(posedge sda_w) if (scl_w) begin
    s_act = 0; s_pull = 0;
  end
  always @(posedge scl_w) if (s_act) begin
    if (bitc < 8) sbyte = {sbyte[6:0], sda_w};
    else if (bitc == 8) mack = sda_w;
    bitc++;
  end
  always @(negedge scl_w) if (s_act) begin
    if (bitc == 8) begin
      if (s_addr) begin
        s_match = (sbyte[7:1] == SADDR);
        s_rd = sbyte[0];
        s_pull = s_match;
      end else if (!s_rd) begin
        wlog.push_back(sbyte);
        s_pull = (sbyte != 8'hEE);
      end else s_pull = 0;
    end else if (bitc == 9) begin
      bitc = 0;
      if (s_addr) begin
        s_addr = 0;
        if (!s_match) begin s_act = 0; s_pull = 0; end
        else if (s_rd) begin txb = next_tx(); s_pull = ~txb[7]; end
        else s_pull = 0;
      end else if (s_rd && !mack) begin
        txb = next_tx(); s_pull = ~txb[7];
      end else s_pull = 0;
    end else if (bitc >= 1 && bitc <= 7 && s_rd && !s_addr) begin
      s_pull = ~txb[7-bitc];
    end
  end

  // driver tasks
  task automatic ctl(input logic [7:0] v);
    @(negedge clk); wr_ctrl = 1; ctrl_wdata = v;
    @(negedge clk); wr_ctrl = 0;
  endtask
  task automatic wdat(input logic [7:0] v);
    @(negedge clk); wr_data = 1; data_wdata = v;
    @(negedge clk); wr_data = 0;
  endtask
  task automatic wait_flag();
    int n = 0;
    do begin @(negedge clk); n++; end while (!ctrl_rd[7] && n < 5000);
    @(negedge clk);
  endtask
  task automatic wait_stop();
    int n = 0;
    do begin @(negedge clk); n++; end while ((ctrl_rd[4] || status != 8'hF8) && n < 5000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 8'hF8, "R1 idle code", {24'd0, status}, 32'hF8);
    chk(ctrl_rd == 8'h00, "R1 ctrl reset", {24'd0, ctrl_rd}, 32'h0);
    chk({scl_oe, sda_oe} == 2'b00, "R1 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

    wdat(8'h77);
    chk(ctrl_rd[3] == 1'b1, "R4 collision set", {31'd0, ctrl_rd[3]}, 32'd1);
    chk(rdata == 8'h00, "R4 data unchanged", {24'd0, rdata}, 32'h0);

    expect_ev(8'h08, 0, 8'h00, "R2 start code");
    ctl(EN | STA);
    wait_flag();
    chk(ctrl_rd[5] == 1'b0, "R2 start self-clear", {31'd0, ctrl_rd[5]}, 32'd0);
    rises = 0;
    repeat (60) @(negedge clk);
    chk(scl_oe == 1'b1 && rises == 0, "R3 hold while flag", {31'd0, scl_oe}, 32'd1);

    wdat({SADDR, 1'b0});
    chk(ctrl_rd[3] == 1'b0 && rdata == 8'hA4, "R4 accepted write", {24'd0, rdata}, 32'hA4);
    expect_ev(8'h18, 0, 8'h00, "R5 addr+W ack");
    ctl(EN | CLR);
    wait_flag();
    chk(rises == 9, "R11 nine pulses", rises, 32'd9);
    chk(per == 4*DIV, "R11 pulse period", per, 4*DIV);

    wdat(8'h3C);
    expect_ev(8'h28, 0, 8'h00, "R6 data ack");
    ctl(EN | CLR);
    wait_flag();
    wdat(8'hEE);
    expect_ev(8'h30, 0, 8'h00, "R6 data nack");
    ctl(EN | CLR);
    wait_flag();

    expect_ev(8'h10, 0, 8'h00, "R8 repeated start");
    ctl(EN | CLR | STA);
    wait_flag();
    wdat({SADDR, 1'b1});
    expect_ev(8'h40, 0, 8'h00, "R8 direction switch to read");
    ctl(EN | CLR);
    wait_flag();
    expect_ev(8'h50, 1, 8'hC3, "R7 byte with ACK");
    ctl(EN | CLR | ACK);
    wait_flag();
    expect_ev(8'h58, 1, 8'h5A, "R7 byte with NACK");
    ctl(EN | CLR);
    wait_flag();
    chk(ctrl_rd[6] == 1'b0, "R7 ack enable readback", {31'd0, ctrl_rd[6]}, 32'd0);

    ctl(EN | CLR | STO);
    wait_stop();
    chk(status == 8'hF8 && !ctrl_rd[7], "R9 back to idle", {24'd0, status}, 32'hF8);
    chk(ctrl_rd[4] == 1'b0, "R9 stop self-clear", {31'd0, ctrl_rd[4]}, 32'd0);
    chk({scl_oe, sda_oe} == 2'b00, "R9 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    chk(wlog.size() == 2, "R6 bytes seen by slave", wlog.size(), 32'd2);
    if (wlog.size() == 2) begin
      chk(wlog[0] == 8'h3C, "R6 MSB-first byte 0", {24'd0, wlog[0]}, 32'h3C);
      chk(wlog[1] == 8'hEE, "R6 MSB-first byte 1", {24'd0, wlog[1]}, 32'hEE);
    end

    expect_ev(8'h08, 0, 8'h00, "R2 second start");
    ctl(EN | STA);
    wait_flag();
    wdat(8'h20);
    expect_ev(8'h20, 0, 8'h00, "R5 addr+W nack");
    ctl(EN | CLR);
    wait_flag();
    expect_ev(8'h10, 0, 8'h00, "R8 restart after nack");
    ctl(EN | CLR | STA);
    wait_flag();
    wdat(8'h23);
    expect_ev(8'h48, 0, 8'h00, "R5 addr+R nack");
    ctl(EN | CLR);
    wait_flag();
    ctl(EN | CLR | STO);
    wait_stop();
    chk(status == 8'hF8, "R9 second stop", {24'd0, status}, 32'hF8);

    expect_ev(8'h08, 0, 8'h00, "R2 third start");
    ctl(EN | STA);
    wait_flag();
    rival = 1;
    wdat({SADDR, 1'b0});
    expect_ev(8'h38, 0, 8'h00, "R10 arbitration lost");
    ctl(EN | CLR);
    wait_flag();
    chk({scl_oe, sda_oe} == 2'b00, "R10 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    rival = 0;
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R5 all events seen", sb.size(), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule